// File: doc/BRIEF.md
# UART Interrupt Flag and Vector Unit

This block holds the four interrupt flags of a UART peripheral: receive, transmit-ready, start-byte and transmit-complete. It also holds their enables and a break status bit. The UART datapath sends it single-cycle event strobes. The block qualifies those strobes with the error, dormant-mode and break rules, and sets the matching flags. Flags clear when a data buffer is accessed, when software writes the flag register, or when the vector is read or written.

All pending and enabled flags are merged into one interrupt request, which a global enable can mask. A priority encoder picks the most urgent of those flags and returns it as a small even vector number. Reading the vector acknowledges that one flag. Writing the vector acknowledges every flag. A soft-reset input holds the flags and the main enables at their reset values.

Top module: `uart_irq_unit`

## Requirements
- R1: `irq_o` is 1 exactly when `gie_i` is 1 and at least one of the four flags is 1 with its enable also 1.
- R2: The transmit-ready flag (flag bit 1) sets on `ev_tx_ready_i`. It clears one cycle after `txbuf_wr_i`.
- R3: After `rst_ni` falls, and one cycle after any `swrst_i` cycle, the flag register reads 0x02 and `brk_o` is 0. Only transmit-ready is set. The receive and transmit-ready enables (enable bits 0 and 1) are 0. `rst_ni` also clears every other enable, but `swrst_i` leaves the other enables unchanged.
- R4: The receive flag (flag bit 0) sets on an accepted `ev_rx_char_i`. A `rxbuf_rd_i` clears it and also clears `brk_o`.
- R5: A character that arrives with `ev_rx_err_i` does not set the receive flag unless the error enable (enable bit 4) is 1.
- R6: When `dormant_i` is 1 and `mp_mode_i` is 1, only a character with `ev_rx_addr_i` set sets the receive flag. When `dormant_i` is 1 and `mp_mode_i` is 0, no character sets it.
- R7: When the break enable (enable bit 5) is 1, `ev_rx_brk_i` sets both `brk_o` and the receive flag. When that enable is 0, the strobe has no effect.
- R8: `ev_start_i` sets flag bit 2 and `ev_tx_done_i` sets flag bit 3. Register address 0 holds the flags, with bits 3..0 writable and bit 4 reading as `brk_o`. Address 1 holds the six enables in bits 5..0. Writing 0 to a flag bit clears that flag.
- R9: `vec_o` is 0x02, 0x04, 0x06 or 0x08 for the highest-priority flag that is both pending and enabled. Priority runs receive, then transmit-ready, then start-byte, then transmit-complete. `vec_o` is 0x00 when no such flag exists. A flag whose enable is 0 never changes `vec_o`.
- R10: `vec_rd_i` clears only the flag that `vec_o` shows. Any other pending and enabled flag keeps `irq_o` high on the next cycle.
- R11: `vec_wr_i` clears all four flags.
- R12: When a set event and a clear action reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swrst_i | input | 1 | Soft reset, level sensitive |
| gie_i | input | 1 | Global interrupt enable |
| dormant_i | input | 1 | Dormant receive mode |
| mp_mode_i | input | 1 | 1 selects a multiprocessor framing mode |
| ev_tx_ready_i | input | 1 | Transmit buffer can accept a character |
| ev_rx_char_i | input | 1 | Character loaded into the receive buffer |
| ev_rx_err_i | input | 1 | Qualifier: the character had an error |
| ev_rx_addr_i | input | 1 | Qualifier: the character is an address |
| ev_rx_brk_i | input | 1 | Break detected |
| ev_start_i | input | 1 | Start byte received |
| ev_tx_done_i | input | 1 | Frame including stop bit fully shifted out |
| txbuf_wr_i | input | 1 | Transmit buffer write strobe |
| rxbuf_rd_i | input | 1 | Receive buffer read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from `reg_addr_i` |
| vec_rd_i | input | 1 | Vector read strobe |
| vec_wr_i | input | 1 | Vector write strobe |
| vec_o | output | VEC_W | Priority vector |
| irq_o | output | 1 | Interrupt request |
| brk_o | output | 1 | Break status |

## Verification
The properties assume the event and access inputs are single-cycle strobes that are sampled on the rising edge. Several properties hold only when no competing strobe reaches the same flag in that cycle, such as a register write or a soft reset. Their antecedents exclude those cases explicitly. The bench drives every input on the falling edge and returns strobes to 0 after one cycle. It raises two conflicting actions together only in the scenario that tests the set-wins rule.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NSRC = 4;
  localparam int unsigned EN_W = 6;

  typedef enum int unsigned {
    SRC_RX  = 0,
    SRC_TX  = 1,
    SRC_STT = 2,
    SRC_TXC = 3
  } src_e;

  localparam int unsigned EN_RXERR = 4;
  localparam int unsigned EN_BRK   = 5;

  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_EN   = 1'b1;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic q_o
);
  logic q;
  logic hold;

  assign hold = wr_i ? wdata_i : q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= RST_VAL;
    else if (force_i) q <= RST_VAL;
    else              q <= set_i | (hold & ~clr_i);  // set wins
  end

  assign q_o = q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int unsigned N     = 4,
  parameter int unsigned VEC_W = 8
) (
  input  logic [N-1:0]     pend_i,
  output logic [N-1:0]     sel_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N:0] blk;
  assign blk[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign sel_o[i]  = pend_i[i] & ~blk[i];
    assign blk[i+1]  = blk[i] | pend_i[i];
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_o[i]) vec_o = VEC_W'(2 * (i + 1));
    end
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swrst_i,
  input  logic              gie_i,
  input  logic              dormant_i,
  input  logic              mp_mode_i,
  input  logic              ev_tx_ready_i,
  input  logic              ev_rx_char_i,
  input  logic              ev_rx_err_i,
  input  logic              ev_rx_addr_i,
  input  logic              ev_rx_brk_i,
  input  logic              ev_start_i,
  input  logic              ev_tx_done_i,
  input  logic              txbuf_wr_i,
  input  logic              rxbuf_rd_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              vec_rd_i,
  input  logic              vec_wr_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              irq_o,
  output logic              brk_o
);
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] flag_set;
  logic [NSRC-1:0] flag_clr;
  logic [NSRC-1:0] auto_clr;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] sel;
  logic [EN_W-1:0] en_q;
  logic            brk_q;
  logic            brk_hit;
  logic            rx_ok;
  logic            wr_flag;
  logic            wr_en;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:EN_W];

  assign wr_flag = reg_wr_i & (reg_addr_i == ADDR_FLAG);
  assign wr_en   = reg_wr_i & (reg_addr_i == ADDR_EN);

  // receive qualification: error rule, then dormant rule
  assign brk_hit = ev_rx_brk_i & en_q[EN_BRK];
  assign rx_ok   = ev_rx_char_i
                 & (~ev_rx_err_i | en_q[EN_RXERR])
                 & (~dormant_i | (mp_mode_i & ev_rx_addr_i));

  assign flag_set[SRC_RX]  = rx_ok | brk_hit;
  assign flag_set[SRC_TX]  = ev_tx_ready_i;
  assign flag_set[SRC_STT] = ev_start_i;
  assign flag_set[SRC_TXC] = ev_tx_done_i;

  assign auto_clr[SRC_RX]  = rxbuf_rd_i;
  assign auto_clr[SRC_TX]  = txbuf_wr_i;
  assign auto_clr[SRC_STT] = 1'b0;
  assign auto_clr[SRC_TXC] = 1'b0;

  assign flag_clr = auto_clr
                  | ({NSRC{vec_rd_i}} & sel)
                  | {NSRC{vec_wr_i}};

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    uart_irq_flag #(
      .RST_VAL(i == SRC_TX)
    ) u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .force_i (swrst_i),
      .set_i   (flag_set[i]),
      .clr_i   (flag_clr[i]),
      .wr_i    (wr_flag),
      .wdata_i (reg_wdata_i[i]),
      .q_o     (flag_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (swrst_i) begin
      en_q[SRC_RX] <= 1'b0;
      en_q[SRC_TX] <= 1'b0;
    end else if (wr_en) begin
      en_q <= reg_wdata_i[EN_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         brk_q <= 1'b0;
    else if (swrst_i)    brk_q <= 1'b0;
    else if (brk_hit)    brk_q <= 1'b1;
    else if (rxbuf_rd_i) brk_q <= 1'b0;
  end

  assign pend = flag_q & en_q[NSRC-1:0];

  uart_irq_prio #(
    .N     (NSRC),
    .VEC_W (VEC_W)
  ) u_prio (
    .pend_i (pend),
    .sel_o  (sel),
    .vec_o  (vec_o)
  );

  assign irq_o = gie_i & (|pend);
  assign brk_o = brk_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_FLAG) reg_rdata_o[NSRC:0] = {brk_q, flag_q};
    else                         reg_rdata_o[EN_W-1:0] = en_q;
  end
endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             swrst_i,
  input logic             gie_i,
  input logic             dormant_i,
  input logic             mp_mode_i,
  input logic             ev_tx_ready_i,
  input logic             ev_rx_char_i,
  input logic             ev_rx_err_i,
  input logic             ev_rx_brk_i,
  input logic             ev_start_i,
  input logic             ev_tx_done_i,
  input logic             txbuf_wr_i,
  input logic             reg_wr_i,
  input logic             vec_rd_i,
  input logic             vec_wr_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             irq_o,
  input logic             brk_o,
  input logic [NSRC-1:0]  flag_q,
  input logic [EN_W-1:0]  en_q
);
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);  // R1

  AST_TX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txbuf_wr_i && !ev_tx_ready_i && !swrst_i && !reg_wr_i |=> !flag_q[SRC_TX]);  // R2

  AST_SWRST_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_i |=> flag_q == 4'b0010 && en_q[1:0] == 2'b00 && !brk_o);  // R3

  AST_ERR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rx_char_i && ev_rx_err_i && !en_q[EN_RXERR] && !flag_q[SRC_RX]
    && !ev_rx_brk_i && !reg_wr_i && !swrst_i |=> !flag_q[SRC_RX]);  // R5

  AST_DORMANT_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rx_char_i && dormant_i && !mp_mode_i && !flag_q[SRC_RX]
    && !ev_rx_brk_i && !reg_wr_i && !swrst_i |=> !flag_q[SRC_RX]);  // R6

  AST_BREAK_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rx_brk_i && en_q[EN_BRK] && !swrst_i |=> brk_o && flag_q[SRC_RX]);  // R7

  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o == 0 || vec_o == 2 || vec_o == 4 || vec_o == 6 || vec_o == 8);  // R9

  AST_IRQ_HAS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> vec_o != 0);  // R9

  AST_VEC_RD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_i && vec_o == 2 && !ev_rx_char_i && !ev_rx_brk_i && !swrst_i
    && !reg_wr_i && !txbuf_wr_i && !vec_wr_i
    |=> !flag_q[SRC_RX] && ((flag_q[3:1] & $past(flag_q[3:1])) == $past(flag_q[3:1])));  // R10

  AST_VEC_WR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_wr_i && !ev_rx_char_i && !ev_rx_brk_i && !ev_tx_ready_i && !ev_start_i
    && !ev_tx_done_i && !swrst_i |=> flag_q == '0);  // R11

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_tx_ready_i && !swrst_i |=> flag_q[SRC_TX]);  // R12
endmodule

bind uart_irq_unit uart_irq_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .swrst_i       (swrst_i),
  .gie_i         (gie_i),
  .dormant_i     (dormant_i),
  .mp_mode_i     (mp_mode_i),
  .ev_tx_ready_i (ev_tx_ready_i),
  .ev_rx_char_i  (ev_rx_char_i),
  .ev_rx_err_i   (ev_rx_err_i),
  .ev_rx_brk_i   (ev_rx_brk_i),
  .ev_start_i    (ev_start_i),
  .ev_tx_done_i  (ev_tx_done_i),
  .txbuf_wr_i    (txbuf_wr_i),
  .reg_wr_i      (reg_wr_i),
  .vec_rd_i      (vec_rd_i),
  .vec_wr_i      (vec_wr_i),
  .vec_o         (vec_o),
  .irq_o         (irq_o),
  .brk_o         (brk_o),
  .flag_q        (flag_q),
  .en_q          (en_q)
);

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       swrst_i = 0, gie_i = 0, dormant_i = 0, mp_mode_i = 0;
  logic       ev_tx_ready_i = 0, ev_rx_char_i = 0, ev_rx_err_i = 0, ev_rx_addr_i = 0;
  logic       ev_rx_brk_i = 0, ev_start_i = 0, ev_tx_done_i = 0;
  logic       txbuf_wr_i = 0, rxbuf_rd_i = 0, reg_wr_i = 0, reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic       vec_rd_i = 0, vec_wr_i = 0;
  logic [7:0] vec_o;
  logic       irq_o, brk_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  uart_irq_unit u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
    swrst_i = 0; ev_tx_ready_i = 0; ev_rx_char_i = 0; ev_rx_err_i = 0;
    ev_rx_addr_i = 0; ev_rx_brk_i = 0; ev_start_i = 0; ev_tx_done_i = 0;
    txbuf_wr_i = 0; rxbuf_rd_i = 0; reg_wr_i = 0; vec_rd_i = 0; vec_wr_i = 0;
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1; cyc();
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic clean(logic [7:0] en);
    wr_reg(1'b1, en);
    vec_wr_i = 1; cyc();
    dormant_i = 0; mp_mode_i = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(1'b0, d); chk("R3 reset flags", d, 8'h02);
    rd_reg(1'b1, d); chk("R3 reset enables", d, 8'h00);
    chk("R1 reset irq", irq_o, 0);
    chk("R9 reset vec", vec_o, 0);
  endtask

  task automatic t_tx();
    clean(8'h02); gie_i = 1;
    ev_tx_ready_i = 1; cyc();
    chk("R1 irq tx", irq_o, 1);
    chk("R9 vec tx", vec_o, 8'h04);
    gie_i = 0; #1;
    chk("R1 gie masks", irq_o, 0);
    gie_i = 1;
    txbuf_wr_i = 1; cyc();
    chk("R2 tx cleared by write", irq_o, 0);
  endtask

  task automatic t_rx();
    logic [7:0] d;
    clean(8'h03);
    ev_tx_ready_i = 1; ev_rx_char_i = 1; cyc();
    chk("R9 rx over tx", vec_o, 8'h02);
    rd_reg(1'b0, d); chk("R4 rx flag set", d[0], 1);
    rxbuf_rd_i = 1; cyc();
    rd_reg(1'b0, d); chk("R4 rx cleared by read", d[0], 0);
    chk("R9 falls to tx", vec_o, 8'h04);
  endtask

  task automatic t_err();
    logic [7:0] d;
    clean(8'h01);
    ev_rx_char_i = 1; ev_rx_err_i = 1; cyc();
    rd_reg(1'b0, d); chk("R5 error blocked", d[0], 0);
    wr_reg(1'b1, 8'h11);
    ev_rx_char_i = 1; ev_rx_err_i = 1; cyc();
    rd_reg(1'b0, d); chk("R5 error accepted", d[0], 1);
  endtask

  task automatic t_dormant();
    logic [7:0] d;
    clean(8'h01);
    dormant_i = 1; mp_mode_i = 0;
    ev_rx_char_i = 1; ev_rx_addr_i = 1; cyc();
    rd_reg(1'b0, d); chk("R6 plain dormant blocks", d[0], 0);
    mp_mode_i = 1;
    ev_rx_char_i = 1; cyc();
    rd_reg(1'b0, d); chk("R6 mp dormant data blocked", d[0], 0);
    ev_rx_char_i = 1; ev_rx_addr_i = 1; cyc();
    rd_reg(1'b0, d); chk("R6 mp dormant address", d[0], 1);
    dormant_i = 0; mp_mode_i = 0;
  endtask

  task automatic t_break();
    logic [7:0] d;
    clean(8'h01);
    ev_rx_brk_i = 1; cyc();
    rd_reg(1'b0, d); chk("R7 break disabled", d[4:0], 5'h00);
    wr_reg(1'b1, 8'h21);
    ev_rx_brk_i = 1; cyc();
    rd_reg(1'b0, d); chk("R7 break sets", d[4:0], 5'h11);
    chk("R7 brk_o", brk_o, 1);
    rxbuf_rd_i = 1; cyc();
    chk("R4 read clears brk", brk_o, 0);
  endtask

  task automatic t_state();
    logic [7:0] d;
    clean(8'h08);
    ev_start_i = 1; ev_tx_done_i = 1; cyc();
    rd_reg(1'b0, d); chk("R8 start and done set", d[3:0], 4'hC);
    chk("R9 disabled start ignored", vec_o, 8'h08);
    wr_reg(1'b0, 8'h08);
    rd_reg(1'b0, d); chk("R8 start cleared by 0", d[3:0], 4'h8);
    wr_reg(1'b0, 8'h00);
    rd_reg(1'b0, d); chk("R8 done cleared by 0", d[3:0], 4'h0);
  endtask

  task automatic t_vec_rd();
    clean(8'h0F); gie_i = 1;
    ev_rx_char_i = 1; ev_tx_ready_i = 1; ev_start_i = 1; ev_tx_done_i = 1; cyc();
    chk("R9 top rx", vec_o, 8'h02);
    vec_rd_i = 1; cyc();
    chk("R10 next tx", vec_o, 8'h04);
    chk("R10 irq held", irq_o, 1);
    vec_rd_i = 1; cyc();
    chk("R10 next start", vec_o, 8'h06);
    vec_rd_i = 1; cyc();
    chk("R10 next done", vec_o, 8'h08);
    vec_rd_i = 1; cyc();
    chk("R10 none left", vec_o, 8'h00);
    chk("R10 irq drops", irq_o, 0);
  endtask

  task automatic t_vec_wr();
    logic [7:0] d;
    clean(8'h0F);
    ev_rx_char_i = 1; ev_tx_ready_i = 1; ev_start_i = 1; ev_tx_done_i = 1; cyc();
    vec_wr_i = 1; cyc();
    rd_reg(1'b0, d); chk("R11 all cleared", d[3:0], 4'h0);
    chk("R11 irq low", irq_o, 0);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    clean(8'h03);
    ev_tx_ready_i = 1; txbuf_wr_i = 1; cyc();
    rd_reg(1'b0, d); chk("R12 tx set wins", d[1], 1);
    ev_rx_char_i = 1; rxbuf_rd_i = 1; cyc();
    rd_reg(1'b0, d); chk("R12 rx set wins", d[0], 1);
    ev_start_i = 1; vec_wr_i = 1; cyc();
    rd_reg(1'b0, d); chk("R12 start set over vector write", d[3:0], 4'h4);
  endtask

  task automatic t_swrst();
    logic [7:0] d;
    clean(8'h3F);
    ev_rx_char_i = 1; ev_start_i = 1; ev_tx_done_i = 1; cyc();
    swrst_i = 1; cyc();
    rd_reg(1'b0, d); chk("R3 swrst flags", d, 8'h02);
    rd_reg(1'b1, d); chk("R3 swrst enables", d, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    cyc();
    t_reset();
    t_tx();
    t_rx();
    t_err();
    t_dormant();
    t_break();
    t_state();
    t_vec_rd();
    t_vec_wr();
    t_set_wins();
    t_swrst();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule